// File: doc/BRIEF.md
# Reaction Timer with Two-Digit Decimal Display

This block measures how long a person takes to respond to a light, in hundredths of a second. A one-cycle start pulse turns the LED on and arms a two-digit decimal counter. The person then presses a push-button, and the count stops and holds the elapsed time. Both decimal digits are driven out as seven-segment patterns, ready for a display driver.

A free-running power-of-two prescaler divides the system clock into a single-cycle count tick. From a 102.4 kHz clock with the default 10-bit prescaler, the tick rate is 100 Hz. The tick is a clock enable inside the one clock domain, not a derived clock. A single state flop gates counting. The units digit advances on each tick while the flop is set. The tens digit advances only when the units digit wraps from 9. The count stops at 99 rather than rolling over.

The button idles high and passes through a two-flop synchronizer before it reaches the state flop. A held press wins over a start pulse. A later start pulse resumes counting from the held value. Only reset returns the display to 00.

Top module: `rxn_timer`

## Requirements
- R1: A synchronous active-low reset clears both digits, the prescaler and the state flop. After reset, led is 0 and both segment outputs show the pattern for 0.
- R2: Number the rising edges from 1, starting after the last edge that samples rst_n low. A count tick takes effect on every edge whose number is a multiple of 2^PRESCALE_BITS.
- R3: When start_w is 1 at an edge and the synchronized button is released, the state flop is set and led becomes 1 after that edge. Only ticks at later edges are counted.
- R4: While led is 1, each tick advances the units digit through 0..9. On a tick with units at 9, units returns to 0 and tens advances by one at the same edge. Tens never changes otherwise.
- R5: Once the count reaches 99 it holds at 99 on further ticks while led stays 1.
- R6: btn_n is active-low. If btn_n is first sampled low at edge b, it reaches the state logic through two flops and clears the state flop at edge b+2. A tick at edge b+2 is still counted, and the value is held afterwards.
- R7: While the synchronized button is pressed (low), a start_w pulse is ignored and led stays 0.
- R8: A start pulse after a stop resumes counting from the held value without clearing it.
- R9: Segment outputs are active-high with bit 0 = a through bit 6 = g. Digits 0..9 map to hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R10: While led is 0, ticks leave both digits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_w | input | 1 | One-cycle start pulse |
| btn_n | input | 1 | Push-button, low when pressed, asynchronous |
| led | output | 1 | Stimulus light, high while timing |
| seg_tens | output | 7 | Tens digit segments, bit 0 = a .. bit 6 = g |
| seg_units | output | 7 | Units digit segments, bit 0 = a .. bit 6 = g |

## Verification
The assertions assume start_w is driven synchronously to clk. They also assume reset is held low for at least two edges, so the stability and step properties have a defined previous value once reset is released. The button is treated as asynchronous only up to the synchronizer; the properties about stopping refer to its synchronized output. The bench drives every input on the falling edge. It holds reset for several cycles and asserts start only after the button has been released for many cycles. It predicts the held count from the edge numbers of the start pulse and the press, using the tick cadence and the two-edge button latency.

// File: rtl/rt_pkg.sv
// Package: shared types and the seven-segment encoding for the reaction timer.
// Assumes BCD digits never exceed 9; any other value encodes as blank.
package rt_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [6:0] seg_t;

    localparam bcd_t BCD_TOP = 4'd9;

    // Active-high segments, bit 0 = a ... bit 6 = g.
    function automatic seg_t seg_of(input bcd_t d);
        seg_t s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rt_prescaler.sv
// Module: free-running power-of-two divider producing a one-cycle tick.
// The tick is high for the single cycle in which the counter holds all ones.
// Assumes the consumer uses tick as a clock enable in the same domain.
module rt_prescaler #(
    parameter int WIDTH = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    logic [WIDTH-1:0] div_q;

    // Advance the divider every cycle; wraps naturally at 2^WIDTH.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign tick = &div_q;

endmodule

// File: rtl/rt_sync.sv
// Module: multi-flop synchronizer for an asynchronous level input.
// Resets to RESET_VAL so an idle-high input looks idle during reset.
// Assumes STAGES is at least 2.
module rt_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rt_bcd_digit.sv
// Module: one decimal digit, 0..9, advanced by a single-cycle enable.
// at_max flags the value 9 so the caller can cascade digits.
// Assumes the enable already includes any saturation gating.
module rt_bcd_digit
    import rt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc_en,
    output bcd_t q,
    output logic at_max
);

    bcd_t val_q;

    // Step the digit, wrapping from 9 back to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (inc_en) val_q <= (val_q == BCD_TOP) ? '0 : val_q + 4'd1;
    end

    assign q      = val_q;
    assign at_max = (val_q == BCD_TOP);

endmodule

// File: rtl/rt_seg_enc.sv
// Module: combinational BCD to seven-segment encoder, active-high a..g.
// Assumes a digit in 0..9; other codes produce a blank pattern.
module rt_seg_enc
    import rt_pkg::*;
(
    input  bcd_t digit,
    output seg_t seg
);

    // Look the pattern up through the shared encoding function.
    always_comb seg = seg_of(digit);

endmodule

// File: rtl/rxn_timer.sv
// Module: reaction timer. A prescaler tick advances a cascaded decimal
// counter while a state flop is set. start_w sets the flop, a synchronized
// button press clears it, and the count saturates at all nines.
// Assumes start_w is synchronous to clk and btn_n idles high.
module rxn_timer
    import rt_pkg::*;
#(
    parameter int PRESCALE_BITS = 10,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_w,
    input  logic       btn_n,
    output logic       led,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_units
);

    localparam int NUM_DIGITS = 2;

    logic                  tick;
    logic                  btn_s;
    logic                  run_q;
    logic                  saturated;
    bcd_t                  digit_q   [NUM_DIGITS];
    seg_t                  seg_bus   [NUM_DIGITS];
    logic [NUM_DIGITS-1:0] digit_max;
    logic [NUM_DIGITS-1:0] step_en;

    rt_prescaler #(.WIDTH(PRESCALE_BITS)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_btn_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (btn_n),
        .q     (btn_s)
    );

    // State flop: a press clears it and wins over a start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (!btn_s)  run_q <= 1'b0;
        else if (start_w) run_q <= 1'b1;
    end

    assign saturated  = &digit_max;
    assign step_en[0] = run_q & tick & ~saturated;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        rt_bcd_digit u_digit (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_en (step_en[i]),
            .q      (digit_q[i]),
            .at_max (digit_max[i])
        );

        rt_seg_enc u_enc (
            .digit (digit_q[i]),
            .seg   (seg_bus[i])
        );

        if (i + 1 < NUM_DIGITS) begin : g_carry
            assign step_en[i+1] = step_en[i] & digit_max[i];
        end
    end

    assign led       = run_q;
    assign seg_units = seg_bus[0];
    assign seg_tens  = seg_bus[1];

endmodule

// File: rtl/rxn_timer_chk.sv
// Module: property checker for the reaction timer, bound to the top.
// Assumes reset is held low for at least two edges at start-up.
module rxn_timer_chk
    import rt_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic start_w,
    input logic btn_s,
    input logic led,
    input bcd_t units,
    input bcd_t tens
);

    logic rst_was_low;

    // Remember whether the previous edge sampled reset asserted.
    always_ff @(posedge clk) rst_was_low <= !rst_n;

    // R1: the edge after a reset edge sees everything cleared.
    always_ff @(posedge clk) begin
        if (rst_was_low) begin
            p_reset_clear_r1: assert (units == 4'd0 && tens == 4'd0 && !led)
                else $error("p_reset_clear_r1");
        end
    end

    p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (units <= BCD_TOP) && (tens <= BCD_TOP));

    p_units_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(units) |-> ((units == $past(units) + 4'd1) ||
                             (units == 4'd0 && $past(units) == BCD_TOP)));

    p_tens_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tens) |-> ($past(units) == BCD_TOP && units == 4'd0));

    p_hold_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tens == BCD_TOP && units == BCD_TOP) |=> (tens == BCD_TOP && units == BCD_TOP));

    p_start_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && btn_s) |=> led);

    p_press_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_s |=> !led);

    p_idle_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !led |=> ($stable(units) && $stable(tens)));

endmodule

bind rxn_timer rxn_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_w (start_w),
    .btn_s   (btn_s),
    .led     (led),
    .units   (digit_q[0]),
    .tens    (digit_q[1])
);

// File: tb/tb_rxn_timer.sv
// Directed bench for the reaction timer. It uses a short prescaler so that
// ticks land every TICK cycles and predicts each held count from edge numbers.
module tb_rxn_timer;

    localparam int PB   = 4;
    localparam int TICK = 1 << PB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_w = 1'b0;
    logic       btn_n = 1'b1;
    logic       led;
    logic [6:0] seg_tens;
    logic [6:0] seg_units;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    rxn_timer #(.PRESCALE_BITS(PB)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_w   (start_w),
        .btn_n     (btn_n),
        .led       (led),
        .seg_tens  (seg_tens),
        .seg_units (seg_units)
    );

    always #10 clk = ~clk;

    // Edge number since the last reset edge.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [6:0] seg_ref(input int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    // Ticks falling on edges in (from_e, to_e].
    function automatic int ticks_between(input int from_e, input int to_e);
        return (to_e / TICK) - (from_e / TICK);
    endfunction

    function automatic int clamp99(input int v);
        return (v > 99) ? 99 : v;
    endfunction

    task automatic check_count(input string req, input int exp_val);
        n_checks++;
        if (seg_tens !== seg_ref(exp_val / 10) || seg_units !== seg_ref(exp_val % 10)) begin
            n_fail++;
            $display("FAIL %s count: segs tens=%h units=%h expected tens=%h units=%h (value %0d)",
                     req, seg_tens, seg_units, seg_ref(exp_val / 10), seg_ref(exp_val % 10), exp_val);
        end
    endtask

    task automatic check_led(input string req, input logic exp_led);
        n_checks++;
        if (led !== exp_led) begin
            n_fail++;
            $display("FAIL %s led: actual=%b expected=%b", req, led, exp_led);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        start_w = 1'b0;
        btn_n   = 1'b1;
        wait_cycles(4);
        rst_n = 1'b1;
    endtask

    // Pulse start for one edge; returns that edge's number.
    task automatic pulse_start(output int e);
        start_w = 1'b1;
        e = cyc + 1;
        @(negedge clk);
        start_w = 1'b0;
    endtask

    // Hold the button low for hold edges; returns the first low edge.
    task automatic press(input int hold, output int b);
        btn_n = 1'b0;
        b = cyc + 1;
        wait_cycles(hold);
        btn_n = 1'b1;
    endtask

    task automatic test_reset();
        do_reset();
        wait_cycles(1);
        check_led("R1", 1'b0);
        check_count("R1", 0);
        wait_cycles(3 * TICK);
        check_count("R10", 0);
    endtask

    task automatic test_short_run();
        int e, b, v;
        do_reset();
        wait_cycles(3);
        pulse_start(e);
        check_led("R3", 1'b1);
        wait_cycles(45);
        press(3, b);
        wait_cycles(5);
        v = ticks_between(e, b + 2);
        check_count("R6", v);
        check_led("R6", 1'b0);
        wait_cycles(5 * TICK);
        check_count("R10", v);
    endtask

    task automatic test_walk();
        int e, b;
        do_reset();
        wait_cycles(7);
        pulse_start(e);
        for (int k = 0; k < 25; k++) begin
            wait_cycles(TICK);
            check_count("R4/R9/R2", clamp99(ticks_between(e, cyc)));
        end
        press(2, b);
        wait_cycles(4);
    endtask

    task automatic test_saturate();
        int e, b;
        do_reset();
        wait_cycles(2);
        pulse_start(e);
        for (int k = 0; k < 11; k++) begin
            wait_cycles(10 * TICK);
            check_count("R9/R4", clamp99(ticks_between(e, cyc)));
        end
        wait_cycles(6 * TICK);
        check_count("R5", 99);
        check_led("R5", 1'b1);
        press(2, b);
        wait_cycles(4);
        check_count("R5", 99);
        check_led("R6", 1'b0);
    endtask

    task automatic test_blocked_then_resume();
        int e, b, b2, e2, v;
        do_reset();
        wait_cycles(5);
        pulse_start(e);
        wait_cycles(50);
        btn_n = 1'b0;
        b = cyc + 1;
        wait_cycles(4);
        pulse_start(e2);
        wait_cycles(3);
        btn_n = 1'b1;
        wait_cycles(4 * TICK);
        v = ticks_between(e, b + 2);
        check_led("R7", 1'b0);
        check_count("R7", v);
        pulse_start(e2);
        check_led("R8", 1'b1);
        wait_cycles(70);
        press(2, b2);
        wait_cycles(5);
        check_count("R8", clamp99(v + ticks_between(e2, b2 + 2)));
    endtask

    task automatic test_reset_midrun();
        int e;
        do_reset();
        wait_cycles(1);
        pulse_start(e);
        wait_cycles(7 * TICK);
        do_reset();
        wait_cycles(1);
        check_led("R1", 1'b0);
        check_count("R1", 0);
    endtask

    initial begin
        test_reset();
        test_short_run();
        test_walk();
        test_saturate();
        test_blocked_then_resume();
        test_reset_midrun();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule